// File: doc/BRIEF.md
# Cross-Clock Timer Register Update Bridge

This block sits between a CPU register port on the system clock and a small 8-bit timer whose clock can be either the system clock or a free-running oscillator input with no phase relation to it. The timer keeps three registers of its own: a count, a compare value and a control byte. In oscillator mode each CPU write is parked in a holding register and carried across the clock boundary by a toggle request and acknowledge handshake. The write has its own busy flag, so software can poll the status byte before it writes that register again.

Each of the three transfer channels is a two-state machine. **XF_IDLE** takes the transition *accept* to **XF_BUSY** when a write arrives in oscillator mode. **XF_BUSY** takes the transition *acknowledged* back to XF_IDLE when the synchronized acknowledge toggle matches the request toggle. The transition *flush* forces either state to XF_IDLE. The clock-source manager has two states. **MD_RUN** takes the transition *source_change* to **MD_FLUSH** when software writes a different clock-select value. **MD_FLUSH** holds the timer domain in reset and clears the channels, then takes the transition *flush_done* back to MD_RUN after FLUSH_CYC cycles.

A count read returns the running timer value, which crosses the boundary as Gray code. Compare and control reads return the holding copies. When the count steps onto the compare value, a single-cycle pulse is returned to the system side.

Top module: `tmr_xfer_bridge`

## Requirements
- R1: After reset, every read address returns 0. Address 0 is status, 1 is count, 2 is compare and 3 is control.
- R2: Status bit 3 is the clock select (0 = system clock, 1 = oscillator input) and can be written. Bits 2, 1 and 0 are the busy flags for count, compare and control; they are read-only. Bits 7 to 4 read 0.
- R3: With select at 0, a write reaches the timer register at the next system clock edge, the compare and control values read back on the following cycle, and no busy flag rises.
- R4: With select at 1, a write raises its busy flag in the next cycle. The flag falls only after the value has reached the timer register, and it falls within a bounded number of cycles.
- R5: A write to a register whose busy flag is set is dropped, and the holding register keeps the earlier value.
- R6: A count read returns the live timer value after synchronization. Compare and control reads return the holding register, which reflects a write at once even while its transfer is still pending.
- R7: Writing a changed select value clears the three timer registers, the holding registers and all busy flags. Every write during the FLUSH_CYC cycles that follow is dropped. Writing the same select value changes nothing.
- R8: The count increments by one on every timer clock while control bits 2..0 are not all zero, and it holds while they are all zero. A count write takes priority over the increment.
- R9: Each increment that lands the count on the compare value produces exactly one single-cycle high on `match_pulse`.
- R10: Between timer clock edges without a count write, the Gray-coded count changes in at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset |
| tosc_clk | input | 1 | Oscillator clock input, asynchronous to sys_clk |
| cpu_wr | input | 1 | Write strobe, sampled on sys_clk |
| cpu_addr | input | 2 | Register select: 0 status, 1 count, 2 compare, 3 control |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for cpu_addr, combinational |
| match_pulse | output | 1 | One-cycle pulse in sys_clk domain on compare match |

## Verification
The hardest state to reach is a second write to a register while its first transfer is still in flight. From the ports, that window lasts only as long as the handshake round trip. The bench switches to the oscillator clock, which is slower than the system clock and has a period that does not divide into it. It then writes compare and, two cycles later, writes it again, before the acknowledge can return. Holding-register read-back and the value seen after the busy flag clears both show that the second write was dropped. A second case writes compare during the flush window that opens right after a clock-source change, then confirms that the write left no trace.

// File: rtl/tmr_bridge_pkg.sv
package tmr_bridge_pkg;

    localparam int TMR_W = 8;

    typedef enum logic [1:0] {
        REG_STAT = 2'd0,
        REG_CNT  = 2'd1,
        REG_CMP  = 2'd2,
        REG_CTL  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        XF_IDLE = 1'b0,
        XF_BUSY = 1'b1
    } xfer_state_e;

    typedef enum logic {
        MD_RUN   = 1'b0,
        MD_FLUSH = 1'b1
    } mode_state_e;

    localparam int STAT_SEL_BIT = 3;

    function automatic logic [TMR_W-1:0] to_gray(input logic [TMR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [TMR_W-1:0] from_gray(input logic [TMR_W-1:0] g);
        logic [TMR_W-1:0] b;
        b[TMR_W-1] = g[TMR_W-1];
        for (int i = TMR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/tmr_xfer_chan.sv
module tmr_xfer_chan
    import tmr_bridge_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         sys_clk,
    input  logic         sys_rst_n,
    input  logic         flush,
    input  logic         async_mode,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] hold_q,
    output logic         busy,
    input  logic         tclk,
    input  logic         trst_n,
    output logic         ld_t,
    output logic [W-1:0] ld_data
);

    xfer_state_e st_q, st_d;
    logic [W-1:0] hold_r;
    logic         req_tog_q;
    logic         ack_s1_q, ack_s2_q;
    logic         rq_s1_t, rq_s2_t, rq_s3_t;
    logic         accept;

    assign accept = wr_en && (st_q == XF_IDLE);

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            XF_IDLE: if (accept && async_mode) st_d = XF_BUSY;
            XF_BUSY: if (ack_s2_q == req_tog_q) st_d = XF_IDLE;
        endcase
        if (flush) st_d = XF_IDLE;
    end

    // state register
    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) st_q <= XF_IDLE;
        else            st_q <= st_d;
    end

    // holding register, request toggle, acknowledge synchronizer
    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            hold_r    <= '0;
            req_tog_q <= 1'b0;
            ack_s1_q  <= 1'b0;
            ack_s2_q  <= 1'b0;
        end else if (flush) begin
            hold_r    <= '0;
            req_tog_q <= 1'b0;
            ack_s1_q  <= 1'b0;
            ack_s2_q  <= 1'b0;
        end else begin
            ack_s1_q <= rq_s3_t;
            ack_s2_q <= ack_s1_q;
            if (accept) begin
                hold_r <= wdata;
                if (async_mode) req_tog_q <= ~req_tog_q;
            end
        end
    end

    // timer-side request synchronizer; third stage doubles as acknowledge
    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) begin
            rq_s1_t <= 1'b0;
            rq_s2_t <= 1'b0;
            rq_s3_t <= 1'b0;
        end else begin
            rq_s1_t <= req_tog_q;
            rq_s2_t <= rq_s1_t;
            rq_s3_t <= rq_s2_t;
        end
    end

    // outputs
    always_comb begin
        busy    = (st_q == XF_BUSY);
        hold_q  = hold_r;
        ld_t    = async_mode ? (rq_s2_t ^ rq_s3_t) : (wr_en && !flush);
        ld_data = async_mode ? hold_r : wdata;
    end

    assert_busy_rise_R4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n || flush)
        (wr_en && async_mode && !busy) |=> busy);

    assert_drop_while_busy_R5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n || flush)
        (wr_en && busy) |=> $stable(hold_q));

    assert_no_busy_sync_R3: assert property (@(posedge sys_clk) disable iff (!sys_rst_n || flush)
        !async_mode |-> !busy);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_bridge_pkg::*;
#(
    parameter int W = TMR_W
) (
    input  logic         tclk,
    input  logic         trst_n,
    input  logic         ld_cnt,
    input  logic         ld_cmp,
    input  logic         ld_ctl,
    input  logic [W-1:0] cnt_d,
    input  logic [W-1:0] cmp_d,
    input  logic [2:0]   ctl_d,
    output logic [W-1:0] gray_q,
    output logic         match_tog
);

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q, cmp_q, cnt_inc;
    logic [2:0]   run_sel_q;
    logic         run, match_q;

    assign run     = (run_sel_q != 3'd0);
    assign cnt_inc = cnt_q + ONE;

    always_ff @(posedge tclk or negedge trst_n) begin
        if (!trst_n) begin
            cnt_q     <= '0;
            cmp_q     <= '0;
            run_sel_q <= '0;
            gray_q    <= '0;
            match_q   <= 1'b0;
        end else begin
            if (ld_cnt)   cnt_q <= cnt_d;
            else if (run) cnt_q <= cnt_inc;
            if (ld_cmp) cmp_q     <= cmp_d;
            if (ld_ctl) run_sel_q <= ctl_d;
            gray_q <= to_gray(cnt_q);
            if (!ld_cnt && run && (cnt_inc == cmp_q)) match_q <= ~match_q;
        end
    end

    assign match_tog = match_q;

    assert_hold_stopped_R8: assert property (@(posedge tclk) disable iff (!trst_n)
        (!run && !ld_cnt) |=> $stable(cnt_q));

    assert_gray_one_bit_R10: assert property (@(posedge tclk) disable iff (!trst_n)
        !ld_cnt |=> ($countones(gray_q ^ to_gray(cnt_q)) <= 1));

endmodule

// File: rtl/tmr_xfer_bridge.sv
module tmr_xfer_bridge
    import tmr_bridge_pkg::*;
#(
    parameter int W         = TMR_W,
    parameter int FLUSH_CYC = 4
) (
    input  logic         sys_clk,
    input  logic         sys_rst_n,
    input  logic         tosc_clk,
    input  logic         cpu_wr,
    input  logic [1:0]   cpu_addr,
    input  logic [W-1:0] cpu_wdata,
    output logic [W-1:0] cpu_rdata,
    output logic         match_pulse
);

    localparam int NCH = 3;
    localparam int FW  = $clog2(FLUSH_CYC + 1);

    mode_state_e md_q, md_d;
    logic [FW-1:0] fl_cnt_q;
    logic          sel_q, flush, trst_n, tclk, stat_wr, sel_chg;

    logic [NCH-1:0] wr_v, busy_v, ld_v;
    logic [W-1:0]   hold_v [NCH];
    logic [W-1:0]   ldd_v  [NCH];

    logic [W-1:0] gray_t, gray_s1_q, gray_s2_q;
    logic         mtog_t, m_s1_q, m_s2_q, m_s3_q;

    assign stat_wr = cpu_wr && (cpu_addr == REG_STAT) && (md_q == MD_RUN);
    assign sel_chg = stat_wr && (cpu_wdata[STAT_SEL_BIT] != sel_q);

    // clock-source manager: next state
    always_comb begin
        md_d = md_q;
        unique case (md_q)
            MD_RUN:   if (sel_chg) md_d = MD_FLUSH;
            MD_FLUSH: if (fl_cnt_q == FW'(1)) md_d = MD_RUN;
        endcase
    end

    // clock-source manager: state register
    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) md_q <= MD_RUN;
        else            md_q <= md_d;
    end

    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            sel_q    <= 1'b0;
            fl_cnt_q <= '0;
        end else if (sel_chg) begin
            sel_q    <= ~sel_q;
            fl_cnt_q <= FW'(FLUSH_CYC);
        end else if (fl_cnt_q != '0) begin
            fl_cnt_q <= fl_cnt_q - FW'(1);
        end
    end

    assign flush  = (md_q == MD_FLUSH);
    assign trst_n = sys_rst_n && !flush;
    assign tclk   = sel_q ? tosc_clk : sys_clk;

    // channel k serves address k+1: count, compare, control
    for (genvar k = 0; k < NCH; k++) begin : g_chan
        assign wr_v[k] = cpu_wr && (cpu_addr == 2'(k + 1)) && !flush;
        tmr_xfer_chan #(.W(W)) chan_i (
            .sys_clk   (sys_clk),
            .sys_rst_n (sys_rst_n),
            .flush     (flush),
            .async_mode(sel_q),
            .wr_en     (wr_v[k]),
            .wdata     (cpu_wdata),
            .hold_q    (hold_v[k]),
            .busy      (busy_v[k]),
            .tclk      (tclk),
            .trst_n    (trst_n),
            .ld_t      (ld_v[k]),
            .ld_data   (ldd_v[k])
        );
    end

    tmr_core #(.W(W)) core_i (
        .tclk     (tclk),
        .trst_n   (trst_n),
        .ld_cnt   (ld_v[0]),
        .ld_cmp   (ld_v[1]),
        .ld_ctl   (ld_v[2]),
        .cnt_d    (ldd_v[0]),
        .cmp_d    (ldd_v[1]),
        .ctl_d    (ldd_v[2][2:0]),
        .gray_q   (gray_t),
        .match_tog(mtog_t)
    );

    // return path: Gray count and match toggle into the system domain
    always_ff @(posedge sys_clk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            gray_s1_q <= '0;
            gray_s2_q <= '0;
            m_s1_q    <= 1'b0;
            m_s2_q    <= 1'b0;
            m_s3_q    <= 1'b0;
        end else if (flush) begin
            gray_s1_q <= '0;
            gray_s2_q <= '0;
            m_s1_q    <= 1'b0;
            m_s2_q    <= 1'b0;
            m_s3_q    <= 1'b0;
        end else begin
            gray_s1_q <= gray_t;
            gray_s2_q <= gray_s1_q;
            m_s1_q    <= mtog_t;
            m_s2_q    <= m_s1_q;
            m_s3_q    <= m_s2_q;
        end
    end

    // outputs
    always_comb begin
        match_pulse = m_s2_q ^ m_s3_q;
        unique case (cpu_addr)
            REG_STAT: cpu_rdata = {{(W-4){1'b0}}, sel_q, busy_v[0], busy_v[1], busy_v[2]};
            REG_CNT:  cpu_rdata = from_gray(gray_s2_q);
            REG_CMP:  cpu_rdata = hold_v[1];
            REG_CTL:  cpu_rdata = hold_v[2];
        endcase
    end

    assert_flush_clears_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        $rose(flush) |=> (busy_v == '0));

    assert_flush_blocks_sel_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
        (flush && $past(flush)) |-> $stable(sel_q));

    assert_match_single_R9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n || flush)
        match_pulse |=> !match_pulse);

endmodule

// File: tb/tmr_xfer_bridge_tb_top.sv
`timescale 1ns/1ps
module tmr_xfer_bridge_tb_top;

    logic       clk = 1'b0;
    logic       osc = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       match_pulse;

    int n_chk = 0;
    int n_bad = 0;
    int n_match = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always #6.5 osc = ~osc;

    tmr_xfer_bridge dut_i (
        .sys_clk    (clk),
        .sys_rst_n  (rst_n),
        .tosc_clk   (osc),
        .cpu_wr     (cpu_wr),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rdata  (cpu_rdata),
        .match_pulse(match_pulse)
    );

    always @(negedge clk) if (rst_n && match_pulse) n_match++;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_clear(input string tag);
        logic [7:0] s;
        int t;
        t = 0;
        rd(2'd0, s);
        while (s[2:0] != 3'd0 && t < 200) begin
            @(negedge clk);
            rd(2'd0, s);
            t++;
        end
        chk(tag, int'(s[2:0]), 0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] v2;
        int base;

        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state on every address
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset read", int'(v), 0);
        end

        // R3 R6 sync mode: compare read-back sweep, no busy
        for (int i = 0; i < 256; i++) begin
            wr(2'd2, 8'(i));
            rd(2'd2, v);
            chk("R3 compare read-back", int'(v), i);
            rd(2'd0, v);
            chk("R3 no busy in sync mode", int'(v), 0);
        end

        // R3 control read-back with stopped values (low bits zero)
        for (int i = 0; i < 32; i++) begin
            wr(2'd3, 8'(i << 3));
            rd(2'd3, v);
            chk("R3 control read-back", int'(v), i << 3);
        end
        wr(2'd3, 8'd0);

        // R6 R8 sync count writes, held while stopped
        for (int i = 0; i < 256; i += 17) begin
            wr(2'd1, 8'(i));
            idle(4);
            rd(2'd1, v);
            chk("R6 R8 live count after write", int'(v), i);
        end

        // R8 R9 sync run: exact increments and one match
        wr(2'd2, 8'd100);
        wr(2'd1, 8'd90);
        base = n_match;
        wr(2'd3, 8'd1);
        idle(28);
        wr(2'd3, 8'd0);
        idle(6);
        rd(2'd1, v);
        chk("R8 sync increments", int'(v), 120);
        chk("R9 one match pulse", n_match - base, 1);

        // R2 status writes of bits other than select are ignored
        wr(2'd0, 8'hF7);
        rd(2'd0, v);
        chk("R2 status upper bits read zero", int'(v), 0);

        // R7 switch to oscillator clock, write during flush dropped
        wr(2'd3, 8'h18);
        wr(2'd0, 8'h08);
        wr(2'd2, 8'h44);
        idle(8);
        rd(2'd0, v);
        chk("R2 R7 status after switch", int'(v), 8);
        rd(2'd2, v);
        chk("R7 compare cleared", int'(v), 0);
        rd(2'd3, v);
        chk("R7 control cleared", int'(v), 0);
        rd(2'd1, v);
        chk("R7 count cleared", int'(v), 0);

        // R4 R5 R6 async write, second write while busy dropped
        wr(2'd2, 8'h5A);
        rd(2'd0, v);
        chk("R4 compare busy bit1 set", int'(v), 8'h0A);
        rd(2'd2, v);
        chk("R6 holding copy visible at once", int'(v), 8'h5A);
        wr(2'd2, 8'h11);
        rd(2'd2, v);
        chk("R5 write while busy dropped", int'(v), 8'h5A);
        wait_clear("R4 compare busy clears");
        rd(2'd2, v);
        chk("R5 compare after transfer", int'(v), 8'h5A);

        // R4 async compare sweep
        for (int i = 0; i < 16; i++) begin
            wr(2'd2, 8'(i * 13));
            wait_clear("R4 sweep busy clears");
            rd(2'd2, v);
            chk("R4 sweep compare", int'(v), (i * 13) & 255);
        end

        // R4 R6 async count write lands, held while stopped
        wr(2'd1, 8'h33);
        rd(2'd0, v);
        chk("R4 count busy bit2 set", int'(v), 8'h0C);
        wait_clear("R4 count busy clears");
        idle(10);
        rd(2'd1, v);
        chk("R6 async live count", int'(v), 8'h33);

        // R8 R9 R10 async run: match once, count advances at oscillator rate
        wr(2'd2, 8'h40);
        wait_clear("R4 compare busy clears");
        wr(2'd1, 8'h3C);
        wait_clear("R4 count busy clears");
        base = n_match;
        wr(2'd3, 8'h02);
        rd(2'd0, v);
        chk("R4 control busy bit0 set", int'(v), 8'h09);
        wait_clear("R4 control busy clears");
        idle(10);
        rd(2'd1, v);
        idle(20);
        rd(2'd1, v2);
        chk_rng("R8 R10 async advance", int'(8'(v2 - v)), 5, 10);
        idle(20);
        chk("R9 async one match pulse", n_match - base, 1);
        wr(2'd3, 8'h00);
        wait_clear("R4 control busy clears");
        idle(10);
        rd(2'd1, v);
        idle(20);
        rd(2'd1, v2);
        chk("R8 async stopped holds", int'(v2), int'(v));

        // R7 same select value: nothing changes
        wr(2'd0, 8'h08);
        idle(8);
        rd(2'd2, v);
        chk("R7 same select keeps compare", int'(v), 8'h40);

        // R7 switch back to system clock
        wr(2'd0, 8'h00);
        idle(8);
        rd(2'd0, v);
        chk("R7 status after switch back", int'(v), 0);
        rd(2'd2, v);
        chk("R7 compare cleared again", int'(v), 0);
        rd(2'd1, v);
        chk("R7 count cleared again", int'(v), 0);

        finish_up();
    end

endmodule